// File: doc/BRIEF.md
# Measurement cycle sequencer

This block is the control state machine of a colour light sensor. It walks the sensor through its power and measurement cycle. After reset it rests in a low-power Sleep state. A start condition seen on the serial bus wakes it into Idle. From Idle it either falls back to Sleep, when power is off, or runs a one-step warm-up. After the warm-up it repeats measurement cycles for as long as power and measurement stay enabled. Each cycle is an optional Wait, a one-step Init and an Integrate phase. Every length is a count of an external step tick, nominally 2.4 ms apart. The integrate and wait lengths come from 8-bit two's-complement registers, so a value of V gives 256 − V steps. A long-wait bit stretches every wait step to twelve ticks.

When integration ends, four channel results are latched together in the same clock edge, the valid flag is raised, and an end-of-conversion event is issued so that a neighbouring block can evaluate thresholds. A counting stub stands in for the analog converters. Each channel adds a fixed rate per integration step, and the sum saturates at the 16-bit limit. As a result, the clear channel always reads (256 − V) × 1024 capped at 65535. If measurement or power is withdrawn partway through, the cycle is dropped at the next tick and no results are transferred.

Top module: `meas_seq`

## Requirements
- R1: After reset, `phase` is 0 (Sleep) and `integ_active`, `xfer_pulse`, `eoc_event` and `data_valid` are low. Sleep is held until `bus_start` is high at a clock edge, which moves `phase` to 1 (Idle). The phase codes are Sleep 0, Idle 1, Warm-up 2, Wait 3, Init 4 and Integrate 5.
- R2: In Idle with `pwr_on` low, the next clock edge returns `phase` to Sleep.
- R3: When `pwr_on` is high in Idle and no warm-up has completed since power came on, the block enters Warm-up. It leaves Warm-up only on a step tick. No Wait, Init or Integrate phase starts before that tick, even if `meas_en` is high.
- R4: In Idle after warm-up with `meas_en` high, a cycle starts with Wait when `wait_en` is 1 and goes directly to Init when `wait_en` is 0.
- R5: Init lasts exactly one step tick. Integrate lasts exactly 256 − `int_time` step ticks, and `integ_active` is high throughout it.
- R6: Wait lasts 256 − `wait_time` step ticks when `wait_long` is 0, and twelve times that when `wait_long` is 1.
- R7: The clock edge that samples the final Integrate tick returns `phase` to Idle, raises `xfer_pulse` and `eoc_event` together for exactly one cycle, updates all four data outputs and sets `data_valid`.
- R8: With S = 256 − `int_time` steps, the transferred results are min(S·1024, 65535) on `clear_data`, min(S·512, 65535) on `red_data`, min(S·256, 65535) on `green_data` and min(S·128, 65535) on `blue_data`.
- R9: While `pwr_on` and `meas_en` stay high, the block starts the next cycle on the clock edge after a transfer.
- R10: If `meas_en` is low at a step tick during Wait, Init or Integrate, `phase` returns to Idle at that tick, no transfer occurs and the data outputs keep their previous values. No phase other than Sleep or Idle changes without a step tick.
- R11: `data_valid` is low on the cycle after any cycle with `pwr_on` low. A running cycle with `pwr_on` low returns to Sleep at the next step tick without a transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_on | input | 1 | Power enable |
| meas_en | input | 1 | Measurement enable |
| wait_en | input | 1 | Insert the Wait phase before each measurement |
| wait_long | input | 1 | Stretch each wait step to twelve ticks |
| int_time | input | 8 | Integration length register, 256 − value steps |
| wait_time | input | 8 | Wait length register, 256 − value steps |
| bus_start | input | 1 | Pulse for a start condition seen on the serial bus |
| step_tick | input | 1 | One-cycle pulse per 2.4 ms step |
| phase | output | 3 | Current phase code (see R1) |
| integ_active | output | 1 | High while integrating |
| xfer_pulse | output | 1 | One-cycle result transfer strobe |
| eoc_event | output | 1 | End-of-conversion event for threshold evaluation |
| data_valid | output | 1 | Results hold a completed integration |
| clear_data | output | 16 | Clear channel result |
| red_data | output | 16 | Red channel result |
| green_data | output | 16 | Green channel result |
| blue_data | output | 16 | Blue channel result |

## Verification
The properties assume the following about the inputs:
- `step_tick` and `bus_start` are single-cycle pulses.
- The time registers, `wait_en` and `wait_long` do not change while a cycle is running, because they are sampled when a phase is entered.

The stimulus meets these assumptions. It produces one tick every fourth clock and one-cycle bus starts. It also writes the configuration only while the block sits in Idle with measurement disabled. Enables are dropped only at the falling edge, away from the edge that samples them.

// File: rtl/meas_seq_pkg.sv
`timescale 1ns/1ps
package meas_seq_pkg;

  typedef enum logic [2:0] {
    PH_SLEEP = 3'd0,
    PH_IDLE  = 3'd1,
    PH_WARM  = 3'd2,
    PH_WAIT  = 3'd3,
    PH_INIT  = 3'd4,
    PH_INTEG = 3'd5
  } phase_e;

  // Steps encoded by a two's-complement length register of width w.
  function automatic int span_of(input int reg_v, input int w);
    return (1 << w) - reg_v;
  endfunction

  // Ticks in a wait phase, optionally stretched by mult.
  function automatic int wait_len(input int reg_v, input int w, input bit lng, input int mult);
    return span_of(reg_v, w) * (lng ? mult : 1);
  endfunction

  // True for phases whose length is counted in step ticks.
  function automatic bit is_timed(input phase_e p);
    return (p == PH_WARM) || (p == PH_WAIT) || (p == PH_INIT) || (p == PH_INTEG);
  endfunction

endpackage

// File: rtl/meas_seq_timer.sv
`timescale 1ns/1ps
module meas_seq_timer #(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] len,
  input  logic             tick,
  output logic             expire
);

  logic [CNT_W-1:0] remain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      remain_q <= '0;
    end else if (load) begin
      remain_q <= len;
    end else if (tick && (remain_q != '0)) begin
      remain_q <= remain_q - 1'b1;
    end
  end

  // The tick that consumes the last remaining step ends the phase.
  assign expire = tick && (remain_q == CNT_W'(1));

endmodule

// File: rtl/meas_seq_fsm.sv
`timescale 1ns/1ps
module meas_seq_fsm
  import meas_seq_pkg::*;
#(
  parameter int TIME_W    = 8,
  parameter int LONG_MULT = 12,
  parameter int CNT_W     = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pwr_on,
  input  logic              meas_en,
  input  logic              wait_en,
  input  logic              wait_long,
  input  logic [TIME_W-1:0] int_time,
  input  logic [TIME_W-1:0] wait_time,
  input  logic              bus_start,
  input  logic              step_tick,
  input  logic              expire,
  output phase_e            phase_q,
  output logic              load,
  output logic [CNT_W-1:0]  load_len,
  output logic              end_integ,
  output logic              eoc_q
);

  phase_e nxt;
  logic   warm_done_q;
  logic   drop_pwr;
  logic   drop_meas;

  assign drop_pwr  = step_tick && !pwr_on;
  assign drop_meas = step_tick && !meas_en;

  always_comb begin
    nxt       = phase_q;
    end_integ = 1'b0;
    case (phase_q)
      PH_SLEEP: if (bus_start) nxt = PH_IDLE;
      PH_IDLE: begin
        if (!pwr_on)            nxt = PH_SLEEP;
        else if (!warm_done_q)  nxt = PH_WARM;
        else if (meas_en)       nxt = wait_en ? PH_WAIT : PH_INIT;
      end
      PH_WARM: begin
        if (drop_pwr)           nxt = PH_SLEEP;
        else if (expire)        nxt = PH_IDLE;
      end
      PH_WAIT: begin
        if (drop_pwr)           nxt = PH_SLEEP;
        else if (drop_meas)     nxt = PH_IDLE;
        else if (expire)        nxt = PH_INIT;
      end
      PH_INIT: begin
        if (drop_pwr)           nxt = PH_SLEEP;
        else if (drop_meas)     nxt = PH_IDLE;
        else if (expire)        nxt = PH_INTEG;
      end
      PH_INTEG: begin
        if (drop_pwr)           nxt = PH_SLEEP;
        else if (drop_meas)     nxt = PH_IDLE;
        else if (expire) begin
          nxt       = PH_IDLE;
          end_integ = 1'b1;
        end
      end
      default:                  nxt = PH_SLEEP;
    endcase
  end

  // A step counter is armed on every entry into a timed phase.
  assign load = (nxt != phase_q) && is_timed(nxt);

  always_comb begin
    case (nxt)
      PH_WAIT:  load_len = CNT_W'(wait_len(int'(wait_time), TIME_W, wait_long, LONG_MULT));
      PH_INTEG: load_len = CNT_W'(span_of(int'(int_time), TIME_W));
      default:  load_len = CNT_W'(1);
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q     <= PH_SLEEP;
      warm_done_q <= 1'b0;
      eoc_q       <= 1'b0;
    end else begin
      phase_q <= nxt;
      eoc_q   <= end_integ;
      if (!pwr_on)
        warm_done_q <= 1'b0;
      else if ((phase_q == PH_WARM) && (nxt == PH_IDLE))
        warm_done_q <= 1'b1;
    end
  end

endmodule

// File: rtl/meas_seq_results.sv
`timescale 1ns/1ps
module meas_seq_results
  import meas_seq_pkg::*;
#(
  parameter int DATA_W    = 16,
  parameter int NCH       = 4,
  parameter int FULL_STEP = 1024
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       pwr_on,
  input  phase_e                     phase_q,
  input  logic                       step_tick,
  input  logic                       end_integ,
  output logic [NCH-1:0][DATA_W-1:0] ch_data,
  output logic                       xfer_q,
  output logic                       valid_q
);

  for (genvar c = 0; c < NCH; c++) begin : g_chan
    localparam int RATE = FULL_STEP >> c;
    logic [DATA_W-1:0] acc_q;
    logic [DATA_W:0]   sum;
    logic [DATA_W-1:0] acc_nxt;

    assign sum     = {1'b0, acc_q} + (DATA_W+1)'(RATE);
    assign acc_nxt = sum[DATA_W] ? {DATA_W{1'b1}} : sum[DATA_W-1:0];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        acc_q      <= '0;
        ch_data[c] <= '0;
      end else begin
        if (phase_q == PH_INIT)
          acc_q <= '0;
        else if ((phase_q == PH_INTEG) && step_tick)
          acc_q <= acc_nxt;
        // The final step is folded in on the same edge as the transfer.
        if (end_integ)
          ch_data[c] <= acc_nxt;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      xfer_q  <= 1'b0;
      valid_q <= 1'b0;
    end else begin
      xfer_q <= end_integ;
      if (!pwr_on)
        valid_q <= 1'b0;
      else if (end_integ)
        valid_q <= 1'b1;
    end
  end

endmodule

// File: rtl/meas_seq.sv
`timescale 1ns/1ps
module meas_seq
  import meas_seq_pkg::*;
#(
  parameter int TIME_W    = 8,
  parameter int LONG_MULT = 12,
  parameter int DATA_W    = 16,
  parameter int FULL_STEP = 1024
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pwr_on,
  input  logic              meas_en,
  input  logic              wait_en,
  input  logic              wait_long,
  input  logic [TIME_W-1:0] int_time,
  input  logic [TIME_W-1:0] wait_time,
  input  logic              bus_start,
  input  logic              step_tick,
  output logic [2:0]        phase,
  output logic              integ_active,
  output logic              xfer_pulse,
  output logic              eoc_event,
  output logic              data_valid,
  output logic [DATA_W-1:0] clear_data,
  output logic [DATA_W-1:0] red_data,
  output logic [DATA_W-1:0] green_data,
  output logic [DATA_W-1:0] blue_data
);

  localparam int NCH   = 4;
  localparam int CNT_W = $clog2((1 << TIME_W) * LONG_MULT + 1);

  phase_e                     phase_q;
  logic                       load;
  logic [CNT_W-1:0]           load_len;
  logic                       expire;
  logic                       end_integ;
  logic [NCH-1:0][DATA_W-1:0] ch_data;

  meas_seq_fsm #(
    .TIME_W    (TIME_W),
    .LONG_MULT (LONG_MULT),
    .CNT_W     (CNT_W)
  ) u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .pwr_on    (pwr_on),
    .meas_en   (meas_en),
    .wait_en   (wait_en),
    .wait_long (wait_long),
    .int_time  (int_time),
    .wait_time (wait_time),
    .bus_start (bus_start),
    .step_tick (step_tick),
    .expire    (expire),
    .phase_q   (phase_q),
    .load      (load),
    .load_len  (load_len),
    .end_integ (end_integ),
    .eoc_q     (eoc_event)
  );

  meas_seq_timer #(
    .CNT_W (CNT_W)
  ) u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (load),
    .len    (load_len),
    .tick   (step_tick),
    .expire (expire)
  );

  meas_seq_results #(
    .DATA_W    (DATA_W),
    .NCH       (NCH),
    .FULL_STEP (FULL_STEP)
  ) u_results (
    .clk       (clk),
    .rst_n     (rst_n),
    .pwr_on    (pwr_on),
    .phase_q   (phase_q),
    .step_tick (step_tick),
    .end_integ (end_integ),
    .ch_data   (ch_data),
    .xfer_q    (xfer_pulse),
    .valid_q   (data_valid)
  );

  assign phase        = phase_q;
  assign integ_active = (phase_q == PH_INTEG);
  assign clear_data   = ch_data[0];
  assign red_data     = ch_data[1];
  assign green_data   = ch_data[2];
  assign blue_data    = ch_data[3];

endmodule

// File: rtl/meas_seq_chk.sv
`timescale 1ns/1ps
module meas_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       pwr_on,
  input logic       bus_start,
  input logic       step_tick,
  input logic [2:0] phase,
  input logic       xfer_pulse,
  input logic       eoc_event,
  input logic       data_valid,
  input logic       end_integ
);

  // R1
  sleep_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == 3'd0 && !bus_start) |=> (phase == 3'd0));

  // R2
  idle_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == 3'd1 && !pwr_on) |=> (phase == 3'd0));

  // R7
  xfer_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_pulse |-> ($past(phase) == 3'd5 && phase == 3'd1));

  // R7
  xfer_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_pulse |=> !xfer_pulse);

  // R7
  eoc_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eoc_event == xfer_pulse);

  // R7
  end_to_xfer_chk: assert property (@(posedge clk) disable iff (!rst_n)
    end_integ |=> (xfer_pulse && data_valid));

  // R11
  valid_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_on |=> !data_valid);

  // R10
  tick_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase >= 3'd2 && phase <= 3'd5 && !step_tick) |=> $stable(phase));

endmodule

bind meas_seq meas_seq_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .pwr_on     (pwr_on),
  .bus_start  (bus_start),
  .step_tick  (step_tick),
  .phase      (phase),
  .xfer_pulse (xfer_pulse),
  .eoc_event  (eoc_event),
  .data_valid (data_valid),
  .end_integ  (end_integ)
);

// File: tb/meas_seq_bench.sv
`timescale 1ns/1ps
module meas_seq_bench;

  logic        clk = 1'b0;
  logic        rst_n, pwr_on, meas_en, wait_en, wait_long, bus_start, step_tick;
  logic [7:0]  int_time, wait_time;
  logic [2:0]  phase;
  logic        integ_active, xfer_pulse, eoc_event, data_valid;
  logic [15:0] clear_data, red_data, green_data, blue_data;

  int checks = 0;
  int errors = 0;
  bit tick_en = 1'b0;
  int tdiv = 0;

  always #5 clk = ~clk;

  meas_seq u_meas_seq (.*);

  // {wait_en, wait_long, wait_time, int_time, total ticks, clear result}
  localparam logic [41:0] VECS [6] = '{
    {1'b0, 1'b0, 8'hFF, 8'hFF, 8'd2,  16'd1024},
    {1'b1, 1'b0, 8'hFC, 8'hF6, 8'd15, 16'd10240},
    {1'b1, 1'b1, 8'hFE, 8'hFB, 8'd30, 16'd5120},
    {1'b0, 1'b1, 8'h00, 8'hC0, 8'd65, 16'd65535},
    {1'b1, 1'b0, 8'hFF, 8'hBE, 8'd68, 16'd65535},
    {1'b0, 1'b0, 8'h00, 8'hE0, 8'd33, 16'd32768}
  };

  function automatic int chan_exp(input int steps, input int rate);
    int v;
    v = steps * rate;
    return (v > 65535) ? 65535 : v;
  endfunction

  function automatic int wait_exp(input bit wen, input bit wl, input int wt);
    if (!wen) return 0;
    return (256 - wt) * (wl ? 12 : 1);
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  initial begin
    step_tick = 1'b0;
    forever begin
      @(posedge clk);
      #1;
      step_tick = tick_en && (tdiv == 3);
      tdiv = (tdiv + 1) % 4;
    end
  end

  task automatic pulse_start();
    @(posedge clk); #1 bus_start = 1'b1;
    @(posedge clk); #1 bus_start = 1'b0;
  endtask

  task automatic wait_phase(input int p);
    int g = 0;
    while (phase != 3'(p) && g < 5000) begin
      @(negedge clk);
      g++;
    end
  endtask

  // Follows one cycle until the transfer strobe or a dropped cycle.
  task automatic run_cycle(output int tot, output int wt, output int it,
                           output int first_ph, output bit seen);
    int guard = 0;
    tot = 0; wt = 0; it = 0; first_ph = -1; seen = 1'b0;
    while (guard < 20000) begin
      @(negedge clk);
      guard++;
      if (xfer_pulse) begin
        seen = 1'b1;
        break;
      end
      if (first_ph < 0 && phase != 3'd1) first_ph = int'(phase);
      if (step_tick && phase >= 3'd3) tot++;
      if (step_tick && phase == 3'd3) wt++;
      if (step_tick && integ_active) it++;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int tot, wt, it, fp, steps, prev_clear;
    bit seen;
    rst_n = 1'b0; pwr_on = 1'b0; meas_en = 1'b0; wait_en = 1'b0; wait_long = 1'b0;
    bus_start = 1'b0; int_time = 8'hFF; wait_time = 8'hFF;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1 reset state
    @(negedge clk);
    chk("R1 phase after reset", int'(phase), 0);
    chk("R1 valid after reset", int'(data_valid), 0);
    chk("R1 xfer after reset", int'(xfer_pulse), 0);
    chk("R1 integ after reset", int'(integ_active), 0);

    // R1 Sleep held without a bus start, even when powered
    @(posedge clk); #1 pwr_on = 1'b1;
    repeat (10) @(negedge clk);
    chk("R1 sleep held", int'(phase), 0);

    // R2 wake with power off returns to Sleep
    @(posedge clk); #1 pwr_on = 1'b0;
    pulse_start();
    @(negedge clk);
    chk("R1 start to idle", int'(phase), 1);
    @(negedge clk);
    chk("R2 idle to sleep", int'(phase), 0);

    // R3 warm-up blocks measurement until a tick
    @(posedge clk); #1 pwr_on = 1'b1; meas_en = 1'b1;
    pulse_start();
    repeat (6) @(negedge clk);
    chk("R3 held in warm-up", int'(phase), 2);
    meas_en = 1'b0;
    tick_en = 1'b1;
    wait_phase(1);
    chk("R3 warm-up done", int'(phase), 1);

    // R4 R5 R6 R7 R8 table of cycles
    for (int i = 0; i < 6; i++) begin
      logic [41:0] v;
      v = VECS[i];
      @(posedge clk); #1;
      wait_en = v[41]; wait_long = v[40]; wait_time = v[39:32]; int_time = v[31:24];
      meas_en = 1'b1;
      run_cycle(tot, wt, it, fp, seen);
      meas_en = 1'b0;
      steps = 256 - int'(v[31:24]);
      chk("R7 transfer seen", int'(seen), 1);
      chk("R7 eoc with transfer", int'(eoc_event), 1);
      chk("R7 valid set", int'(data_valid), 1);
      chk("R4 first phase", fp, v[41] ? 3 : 4);
      chk("R5 total ticks", tot, int'(v[23:16]));
      chk("R5 integrate ticks", it, steps);
      chk("R6 wait ticks", wt, wait_exp(v[41], v[40], int'(v[39:32])));
      chk("R8 clear", int'(clear_data), int'(v[15:0]));
      chk("R8 red", int'(red_data), chan_exp(steps, 512));
      chk("R8 green", int'(green_data), chan_exp(steps, 256));
      chk("R8 blue", int'(blue_data), chan_exp(steps, 128));
      @(negedge clk);
      chk("R7 single pulse", int'(xfer_pulse), 0);
      chk("R7 back in idle", int'(phase), 1);
    end

    // R9 automatic restart
    @(posedge clk); #1;
    wait_en = 1'b1; wait_long = 1'b0; wait_time = 8'hFE; int_time = 8'hFC;
    meas_en = 1'b1;
    run_cycle(tot, wt, it, fp, seen);
    chk("R9 first cycle done", int'(seen), 1);
    @(negedge clk);
    chk("R9 restarted into wait", int'(phase), 3);
    prev_clear = int'(clear_data);
    chk("R8 restart clear", prev_clear, 4096);

    // R10 drop measurement inside Integrate
    wait_phase(5);
    meas_en = 1'b0;
    seen = 1'b0;
    while (phase == 3'd5) begin
      @(negedge clk);
      if (xfer_pulse) seen = 1'b1;
    end
    chk("R10 back to idle", int'(phase), 1);
    chk("R10 no transfer", int'(seen), 0);
    chk("R10 data kept", int'(clear_data), prev_clear);
    chk("R10 valid kept", int'(data_valid), 1);

    // R11 power removed inside Integrate
    @(posedge clk); #1 meas_en = 1'b1;
    wait_phase(5);
    pwr_on = 1'b0;
    seen = 1'b0;
    @(negedge clk);
    chk("R11 valid cleared", int'(data_valid), 0);
    while (phase == 3'd5) begin
      if (xfer_pulse) seen = 1'b1;
      @(negedge clk);
    end
    chk("R11 to sleep", int'(phase), 0);
    chk("R11 no transfer", int'(seen), 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule